// File: doc/BRIEF.md
# Reduction and Scan Combining Node

This block is one interior node of a binary combining tree that carries collective operations among processors. On the upward sweep it gathers three contributions (the left subtree, its own local processor and the right subtree), waits until every one of them has arrived, combines them with the selected operator and passes the result toward the root. On the downward sweep it takes the value from its parent and hands each of its three participants the value it needs. For a reduction, every participant gets the same global result. For a scan, each participant gets the exclusive prefix or the exclusive suffix of the values in tree order, taken as left subtree, local, right subtree.

A five-bit code arrives with the local processor's value and selects both the kind of collective and the operator. Any participant may abstain, in which case it is left out of the combine. A dedicated collective kind turns the node into a one-bit global OR, which serves as a "done" flag. Signed addition can either wrap or saturate, as chosen by a configuration input, and reports overflow. Unsigned addition reports a carry out.

Top module: `comb_node`

## Requirements
- R1: After synchronous reset, `up_vld_o` and `dn_vld_o` are 0.
- R2: Each of the three up-inputs is captured on a clock edge at which its valid is high. Inputs may arrive in any order and in any cycle. `up_vld_o` is high for exactly one cycle, starting at the clock edge after the edge that captured the last of the three, and it stays low while any input is still missing.
- R3: `loc_code_i` is captured with the local input. Bits [4:3] select the kind: 0 = reduction, 1 = prefix scan, 2 = suffix scan, 3 = global OR. Bits [2:0] select the operator: 0 = OR, 1 = XOR, 2 = signed maximum, 3 = signed add, 4 = unsigned add. The codes 5 to 7 act as OR.
- R4: `up_val_o` is the combination of the left, local and right values under the selected operator. The combine is applied pairwise in the order ((left, local), right). Adds wrap modulo 2^W unless R6 saturation applies.
- R5: An abstaining input is left out of the combine. When all three abstain, `up_abs_o` is 1 and `up_val_o` is the identity of the operator: the most negative value for maximum, and 0 for every other operator.
- R6: For signed add, `up_ovf_o` is 1 when either pairwise step overflows. With `sat_en_i` = 1, an overflowing step clamps to the most positive or most negative value, according to the sign of its operands.
- R7: For unsigned add, `up_ovf_o` is 1 when either pairwise step carries out. For OR, XOR and maximum, `up_ovf_o` is 0.
- R8: `dn_vld_o` rises one cycle after `dn_vld_i`. For a reduction, all three down outputs equal `dn_val_i`.
- R9: For a prefix scan, `lft_dn_o` = down value, `loc_dn_o` = down op left, and `rgt_dn_o` = down op left op local. Abstaining participants are left out.
- R10: For a suffix scan, `rgt_dn_o` = down value, `loc_dn_o` = down op right, and `lft_dn_o` = down op right op local.
- R11: For the global OR kind, only bit 0 of each participant is used. `up_val_o` is their OR in bit 0 with zeros above it, and every down output is bit 0 of `dn_val_i`, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sat_en_i | input | 1 | Saturate signed add on overflow |
| lft_vld_i | input | 1 | Left subtree value valid |
| lft_val_i | input | W | Left subtree up value |
| lft_abs_i | input | 1 | Left subtree abstains |
| rgt_vld_i | input | 1 | Right subtree value valid |
| rgt_val_i | input | W | Right subtree up value |
| rgt_abs_i | input | 1 | Right subtree abstains |
| loc_vld_i | input | 1 | Local processor value valid |
| loc_code_i | input | 5 | Kind and operator code |
| loc_val_i | input | W | Local processor value |
| loc_abs_i | input | 1 | Local processor abstains |
| up_vld_o | output | 1 | Combined up value valid |
| up_val_o | output | W | Combined up value |
| up_abs_o | output | 1 | Every participant abstained |
| up_ovf_o | output | 1 | Overflow or carry flag |
| dn_vld_i | input | 1 | Down value from parent valid |
| dn_val_i | input | W | Down value from parent |
| dn_vld_o | output | 1 | Down outputs valid |
| lft_dn_o | output | W | Down value for left subtree |
| loc_dn_o | output | W | Down value for local processor |
| rgt_dn_o | output | W | Down value for right subtree |

## Verification
The assertions assume that a fresh set of up-inputs does not arrive between one combine and the down-sweep that follows it. This means the captured code and the held operands stay fixed while the down values are being formed. They also assume that no input arrives twice before the node fires. The directed stimulus finishes each up-round completely, then runs its matching down-round, before it offers the next set of values. Each input is driven for one cycle at a time, and the code changes only together with the local input.

// File: rtl/cn_pkg.sv
package cn_pkg;
    typedef enum logic [1:0] {
        CN_REDUCE = 2'd0,
        CN_PREFIX = 2'd1,
        CN_SUFFIX = 2'd2,
        CN_GOR    = 2'd3
    } cn_kind_e;

    typedef enum logic [2:0] {
        CN_OR   = 3'd0,
        CN_XOR  = 3'd1,
        CN_MAX  = 3'd2,
        CN_SADD = 3'd3,
        CN_UADD = 3'd4
    } cn_fn_e;

    typedef struct packed {
        cn_kind_e kind;
        cn_fn_e   fn;
    } cn_code_t;

    localparam int CN_CODE_W = 5;
    localparam int CN_NSLOT  = 3;

    function automatic cn_code_t cn_decode(input logic [CN_CODE_W-1:0] raw);
        cn_code_t c;
        c.kind = cn_kind_e'(raw[4:3]);
        case (raw[2:0])
            3'd1:    c.fn = CN_XOR;
            3'd2:    c.fn = CN_MAX;
            3'd3:    c.fn = CN_SADD;
            3'd4:    c.fn = CN_UADD;
            default: c.fn = CN_OR;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/cn_slot.sv
module cn_slot #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_i,
    input  logic [W-1:0] val_i,
    input  logic         abs_i,
    input  logic         clr_i,
    output logic         have_o,
    output logic [W-1:0] val_o,
    output logic         abs_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            have_o <= 1'b0;
            val_o  <= '0;
            abs_o  <= 1'b1;
        end else begin
            if (clr_i) have_o <= 1'b0;
            if (set_i) begin
                have_o <= 1'b1;
                val_o  <= val_i;
                abs_o  <= abs_i;
            end
        end
    end
endmodule

// File: rtl/cn_alu.sv
module cn_alu
    import cn_pkg::*;
#(
    parameter int W = 32
) (
    input  cn_fn_e       fn_i,
    input  logic         sat_i,
    input  logic [W-1:0] a_i,
    input  logic         a_abs_i,
    input  logic [W-1:0] b_i,
    input  logic         b_abs_i,
    output logic [W-1:0] y_o,
    output logic         y_abs_o,
    output logic         ovf_o
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0]   sum_w;
    logic [W-1:0] raw;
    logic         raw_ovf;

    assign sum_w = {1'b0, a_i} + {1'b0, b_i};

    always_comb begin
        raw     = a_i | b_i;
        raw_ovf = 1'b0;
        case (fn_i)
            CN_XOR: raw = a_i ^ b_i;
            CN_MAX: raw = ($signed(a_i) > $signed(b_i)) ? a_i : b_i;
            CN_SADD: begin
                raw_ovf = (a_i[W-1] == b_i[W-1]) && (sum_w[W-1] != a_i[W-1]);
                raw     = (raw_ovf && sat_i) ? (a_i[W-1] ? SMIN : SMAX) : sum_w[W-1:0];
            end
            CN_UADD: begin
                raw_ovf = sum_w[W];
                raw     = sum_w[W-1:0];
            end
            default: raw = a_i | b_i;
        endcase
    end

    always_comb begin
        y_abs_o = 1'b0;
        y_o     = raw;
        ovf_o   = raw_ovf;
        if (a_abs_i && b_abs_i) begin
            y_abs_o = 1'b1;
            y_o     = (fn_i == CN_MAX) ? SMIN : '0;
            ovf_o   = 1'b0;
        end else if (a_abs_i) begin
            y_o   = b_i;
            ovf_o = 1'b0;
        end else if (b_abs_i) begin
            y_o   = a_i;
            ovf_o = 1'b0;
        end
    end
endmodule

// File: rtl/cn_down.sv
module cn_down
    import cn_pkg::*;
#(
    parameter int W = 32
) (
    input  cn_kind_e     kind_i,
    input  cn_fn_e       fn_i,
    input  logic         sat_i,
    input  logic [W-1:0] dn_i,
    input  logic [W-1:0] l_i,
    input  logic         l_abs_i,
    input  logic [W-1:0] c_i,
    input  logic         c_abs_i,
    input  logic [W-1:0] r_i,
    input  logic         r_abs_i,
    output logic [W-1:0] lft_o,
    output logic [W-1:0] loc_o,
    output logic [W-1:0] rgt_o
);
    logic [W-1:0] near_v, p1, p2;
    logic         near_abs, p1_abs;
    logic         unused_ovf1, unused_ovf2, unused_abs2;

    assign near_v   = (kind_i == CN_SUFFIX) ? r_i : l_i;
    assign near_abs = (kind_i == CN_SUFFIX) ? r_abs_i : l_abs_i;

    cn_alu #(.W(W)) u_step1 (
        .fn_i(fn_i), .sat_i(sat_i),
        .a_i(dn_i), .a_abs_i(1'b0), .b_i(near_v), .b_abs_i(near_abs),
        .y_o(p1), .y_abs_o(p1_abs), .ovf_o(unused_ovf1)
    );

    cn_alu #(.W(W)) u_step2 (
        .fn_i(fn_i), .sat_i(sat_i),
        .a_i(p1), .a_abs_i(p1_abs), .b_i(c_i), .b_abs_i(c_abs_i),
        .y_o(p2), .y_abs_o(unused_abs2), .ovf_o(unused_ovf2)
    );

    always_comb begin
        lft_o = dn_i;
        loc_o = dn_i;
        rgt_o = dn_i;
        case (kind_i)
            CN_PREFIX: begin
                loc_o = p1;
                rgt_o = p2;
            end
            CN_SUFFIX: begin
                loc_o = p1;
                lft_o = p2;
            end
            CN_GOR: begin
                lft_o = {{(W-1){1'b0}}, dn_i[0]};
                loc_o = {{(W-1){1'b0}}, dn_i[0]};
                rgt_o = {{(W-1){1'b0}}, dn_i[0]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/comb_node.sv
module comb_node
    import cn_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sat_en_i,
    input  logic                 lft_vld_i,
    input  logic [W-1:0]         lft_val_i,
    input  logic                 lft_abs_i,
    input  logic                 rgt_vld_i,
    input  logic [W-1:0]         rgt_val_i,
    input  logic                 rgt_abs_i,
    input  logic                 loc_vld_i,
    input  logic [CN_CODE_W-1:0] loc_code_i,
    input  logic [W-1:0]         loc_val_i,
    input  logic                 loc_abs_i,
    output logic                 up_vld_o,
    output logic [W-1:0]         up_val_o,
    output logic                 up_abs_o,
    output logic                 up_ovf_o,
    input  logic                 dn_vld_i,
    input  logic [W-1:0]         dn_val_i,
    output logic                 dn_vld_o,
    output logic [W-1:0]         lft_dn_o,
    output logic [W-1:0]         loc_dn_o,
    output logic [W-1:0]         rgt_dn_o
);
    // slot order: 0 = left, 1 = local, 2 = right (combine order)
    logic [CN_NSLOT-1:0]  in_vld, in_abs, have, hold_abs;
    logic [W-1:0]         in_val   [CN_NSLOT];
    logic [W-1:0]         hold_val [CN_NSLOT];
    logic [W-1:0]         opnd     [CN_NSLOT];
    logic                 fire;
    cn_code_t             code_q;
    cn_fn_e               fn_eff;

    assign in_vld    = {rgt_vld_i, loc_vld_i, lft_vld_i};
    assign in_abs    = {rgt_abs_i, loc_abs_i, lft_abs_i};
    assign in_val[0] = lft_val_i;
    assign in_val[1] = loc_val_i;
    assign in_val[2] = rgt_val_i;
    assign fire      = &have;

    always_ff @(posedge clk) begin
        if (rst)            code_q <= '{kind: CN_REDUCE, fn: CN_OR};
        else if (loc_vld_i) code_q <= cn_decode(loc_code_i);
    end

    assign fn_eff = (code_q.kind == CN_GOR) ? CN_OR : code_q.fn;

    for (genvar i = 0; i < CN_NSLOT; i++) begin : g_slot
        cn_slot #(.W(W)) u_slot (
            .clk(clk), .rst(rst),
            .set_i(in_vld[i]), .val_i(in_val[i]), .abs_i(in_abs[i]),
            .clr_i(fire),
            .have_o(have[i]), .val_o(hold_val[i]), .abs_o(hold_abs[i])
        );
        assign opnd[i] = (code_q.kind == CN_GOR) ? {{(W-1){1'b0}}, hold_val[i][0]}
                                                 : hold_val[i];
    end

    logic [W-1:0] s1_v, s2_v;
    logic         s1_abs, s2_abs, s1_ovf, s2_ovf;

    cn_alu #(.W(W)) u_up1 (
        .fn_i(fn_eff), .sat_i(sat_en_i),
        .a_i(opnd[0]), .a_abs_i(hold_abs[0]), .b_i(opnd[1]), .b_abs_i(hold_abs[1]),
        .y_o(s1_v), .y_abs_o(s1_abs), .ovf_o(s1_ovf)
    );

    cn_alu #(.W(W)) u_up2 (
        .fn_i(fn_eff), .sat_i(sat_en_i),
        .a_i(s1_v), .a_abs_i(s1_abs), .b_i(opnd[2]), .b_abs_i(hold_abs[2]),
        .y_o(s2_v), .y_abs_o(s2_abs), .ovf_o(s2_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            up_vld_o <= 1'b0;
            up_val_o <= '0;
            up_abs_o <= 1'b0;
            up_ovf_o <= 1'b0;
        end else begin
            up_vld_o <= fire;
            if (fire) begin
                up_val_o <= s2_v;
                up_abs_o <= s2_abs;
                up_ovf_o <= s1_ovf | s2_ovf;
            end
        end
    end

    logic [W-1:0] d_lft, d_loc, d_rgt;

    cn_down #(.W(W)) u_down (
        .kind_i(code_q.kind), .fn_i(fn_eff), .sat_i(sat_en_i), .dn_i(dn_val_i),
        .l_i(opnd[0]), .l_abs_i(hold_abs[0]),
        .c_i(opnd[1]), .c_abs_i(hold_abs[1]),
        .r_i(opnd[2]), .r_abs_i(hold_abs[2]),
        .lft_o(d_lft), .loc_o(d_loc), .rgt_o(d_rgt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dn_vld_o <= 1'b0;
            lft_dn_o <= '0;
            loc_dn_o <= '0;
            rgt_dn_o <= '0;
        end else begin
            dn_vld_o <= dn_vld_i;
            if (dn_vld_i) begin
                lft_dn_o <= d_lft;
                loc_dn_o <= d_loc;
                rgt_dn_o <= d_rgt;
            end
        end
    end
endmodule

// File: rtl/comb_node_chk.sv
module comb_node_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   kind,
    input logic [2:0]   fn,
    input logic         up_vld_o,
    input logic [W-1:0] up_val_o,
    input logic         up_abs_o,
    input logic         up_ovf_o,
    input logic         dn_vld_i,
    input logic [W-1:0] dn_val_i,
    input logic         dn_vld_o,
    input logic [W-1:0] lft_dn_o,
    input logic [W-1:0] loc_dn_o,
    input logic [W-1:0] rgt_dn_o
);
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    AST_DN_LATENCY: assert property (@(posedge clk) disable iff (rst)
        dn_vld_i |=> dn_vld_o); // R8
    AST_DN_REDUCE_SAME: assert property (@(posedge clk) disable iff (rst)
        (dn_vld_o && kind == 2'd0) |-> (lft_dn_o == loc_dn_o && loc_dn_o == rgt_dn_o)); // R8
    AST_PREFIX_LEFT_PASS: assert property (@(posedge clk) disable iff (rst)
        (dn_vld_o && kind == 2'd1) |-> (lft_dn_o == $past(dn_val_i))); // R9
    AST_SUFFIX_RIGHT_PASS: assert property (@(posedge clk) disable iff (rst)
        (dn_vld_o && kind == 2'd2) |-> (rgt_dn_o == $past(dn_val_i))); // R10
    AST_GOR_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (up_vld_o && kind == 2'd3) |-> (up_val_o[W-1:1] == '0)); // R11
    AST_NO_FLAG_BITWISE: assert property (@(posedge clk) disable iff (rst)
        (up_vld_o && fn <= 3'd2) |-> !up_ovf_o); // R7
    AST_ABS_IDENTITY: assert property (@(posedge clk) disable iff (rst)
        (up_vld_o && up_abs_o) |->
        (up_val_o == ((fn == 3'd2 && kind != 2'd3) ? SMIN : '0))); // R5
endmodule

bind comb_node comb_node_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst),
    .kind(code_q.kind), .fn(code_q.fn),
    .up_vld_o(up_vld_o), .up_val_o(up_val_o), .up_abs_o(up_abs_o), .up_ovf_o(up_ovf_o),
    .dn_vld_i(dn_vld_i), .dn_val_i(dn_val_i), .dn_vld_o(dn_vld_o),
    .lft_dn_o(lft_dn_o), .loc_dn_o(loc_dn_o), .rgt_dn_o(rgt_dn_o)
);

// File: tb/tb_comb_node.sv
module tb_comb_node;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sat_en_i = 1'b0;
    logic         lft_vld_i = 1'b0, rgt_vld_i = 1'b0, loc_vld_i = 1'b0;
    logic [W-1:0] lft_val_i = '0, rgt_val_i = '0, loc_val_i = '0;
    logic         lft_abs_i = 1'b0, rgt_abs_i = 1'b0, loc_abs_i = 1'b0;
    logic [4:0]   loc_code_i = '0;
    logic         up_vld_o, up_abs_o, up_ovf_o, dn_vld_o;
    logic [W-1:0] up_val_o, lft_dn_o, loc_dn_o, rgt_dn_o;
    logic         dn_vld_i = 1'b0;
    logic [W-1:0] dn_val_i = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    comb_node #(.W(W)) dut (
        .clk(clk), .rst(rst), .sat_en_i(sat_en_i),
        .lft_vld_i(lft_vld_i), .lft_val_i(lft_val_i), .lft_abs_i(lft_abs_i),
        .rgt_vld_i(rgt_vld_i), .rgt_val_i(rgt_val_i), .rgt_abs_i(rgt_abs_i),
        .loc_vld_i(loc_vld_i), .loc_code_i(loc_code_i), .loc_val_i(loc_val_i),
        .loc_abs_i(loc_abs_i),
        .up_vld_o(up_vld_o), .up_val_o(up_val_o), .up_abs_o(up_abs_o), .up_ovf_o(up_ovf_o),
        .dn_vld_i(dn_vld_i), .dn_val_i(dn_val_i), .dn_vld_o(dn_vld_o),
        .lft_dn_o(lft_dn_o), .loc_dn_o(loc_dn_o), .rgt_dn_o(rgt_dn_o)
    );

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic up_round(input logic [4:0] code, input logic sat,
                            input logic [W-1:0] lv, input logic la,
                            input logic [W-1:0] cv, input logic ca,
                            input logic [W-1:0] rv, input logic ra,
                            input logic stagger,
                            input logic [W-1:0] ev, input logic eabs, input logic eovf,
                            input string tag);
        sat_en_i = sat;
        lft_val_i = lv; lft_abs_i = la;
        loc_val_i = cv; loc_abs_i = ca; loc_code_i = code;
        rgt_val_i = rv; rgt_abs_i = ra;
        if (stagger) begin
            rgt_vld_i = 1'b1;
            @(posedge clk); @(negedge clk);
            rgt_vld_i = 1'b0; loc_vld_i = 1'b1;
            @(posedge clk); @(negedge clk);
            loc_vld_i = 1'b0;
            check({"R2 early ", tag}, {31'd0, up_vld_o}, 32'd0);
            lft_vld_i = 1'b1;
            @(posedge clk); @(negedge clk);
            lft_vld_i = 1'b0;
        end else begin
            lft_vld_i = 1'b1; loc_vld_i = 1'b1; rgt_vld_i = 1'b1;
            @(posedge clk); @(negedge clk);
            lft_vld_i = 1'b0; loc_vld_i = 1'b0; rgt_vld_i = 1'b0;
        end
        check({"R2 not yet ", tag}, {31'd0, up_vld_o}, 32'd0);
        @(posedge clk); @(negedge clk);
        check({"R2 valid ", tag}, {31'd0, up_vld_o}, 32'd1);
        check({"value ", tag}, up_val_o, ev);
        check({"R5 abstain flag ", tag}, {31'd0, up_abs_o}, {31'd0, eabs});
        check({"flag ", tag}, {31'd0, up_ovf_o}, {31'd0, eovf});
        @(posedge clk); @(negedge clk);
        check({"R2 one pulse ", tag}, {31'd0, up_vld_o}, 32'd0);
    endtask

    task automatic dn_round(input logic [W-1:0] dv, input logic [W-1:0] el,
                            input logic [W-1:0] ec, input logic [W-1:0] er, input string tag);
        dn_vld_i = 1'b1; dn_val_i = dv;
        @(posedge clk); @(negedge clk);
        dn_vld_i = 1'b0;
        check({"R8 dn valid ", tag}, {31'd0, dn_vld_o}, 32'd1);
        check({"left ", tag}, lft_dn_o, el);
        check({"local ", tag}, loc_dn_o, ec);
        check({"right ", tag}, rgt_dn_o, er);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 up_vld reset", {31'd0, up_vld_o}, 32'd0);
        check("R1 dn_vld reset", {31'd0, dn_vld_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reduce_or;
        up_round(5'b00_000, 0, 32'h0000_0011, 0, 32'h0000_0100, 0, 32'h8000_0000, 0, 1,
                 32'h8000_0111, 0, 0, "R4 reduce OR staggered");
        dn_round(32'hCAFE_0001, 32'hCAFE_0001, 32'hCAFE_0001, 32'hCAFE_0001, "R8 reduce");
    endtask

    task automatic t_xor_max;
        up_round(5'b00_001, 0, 32'hF0F0_0000, 0, 32'h0FF0_0000, 0, 32'h000F_000F, 0, 0,
                 32'hFF0F_000F, 0, 0, "R4 XOR R7 no flag");
        up_round(5'b00_010, 0, 32'hFFFF_FFFB, 0, 32'd3, 0, 32'hFFFF_FF9C, 0, 0,
                 32'd3, 0, 0, "R4 signed MAX");
        up_round(5'b00_010, 0, 32'hFFFF_FFFB, 0, 32'd3, 1, 32'hFFFF_FF9C, 0, 1,
                 32'hFFFF_FFFB, 0, 0, "R5 MAX local abstains");
        up_round(5'b00_111, 0, 32'h1, 0, 32'h2, 0, 32'h4, 0, 0,
                 32'h7, 0, 0, "R3 code 7 acts as OR");
    endtask

    task automatic t_sadd;
        up_round(5'b00_011, 0, 32'd10, 0, 32'hFFFF_FFFD, 0, 32'd4, 0, 0,
                 32'd11, 0, 0, "R4 signed add plain");
        up_round(5'b00_011, 0, 32'h7FFF_FFFF, 0, 32'd1, 0, 32'd0, 0, 0,
                 32'h8000_0000, 0, 1, "R6 signed add wraps");
        up_round(5'b00_011, 1, 32'h7FFF_FFFF, 0, 32'd5, 0, 32'hFFFF_FFF6, 0, 0,
                 32'h7FFF_FFF5, 0, 1, "R6 saturate then add in order");
        up_round(5'b00_011, 1, 32'h8000_0000, 0, 32'hFFFF_FFFF, 0, 32'd0, 0, 0,
                 32'h8000_0000, 0, 1, "R6 saturate negative");
    endtask

    task automatic t_uadd;
        up_round(5'b00_100, 0, 32'hFFFF_FFFF, 0, 32'd2, 0, 32'd0, 0, 0,
                 32'd1, 0, 1, "R7 unsigned carry");
        up_round(5'b00_100, 0, 32'd1, 0, 32'd2, 0, 32'd3, 0, 1,
                 32'd6, 0, 0, "R7 unsigned no carry");
    endtask

    task automatic t_all_abstain;
        up_round(5'b00_010, 0, 32'd7, 1, 32'd8, 1, 32'd9, 1, 0,
                 32'h8000_0000, 1, 0, "R5 MAX identity");
        up_round(5'b00_000, 0, 32'd7, 1, 32'd8, 1, 32'd9, 1, 0,
                 32'h0, 1, 0, "R5 OR identity");
    endtask

    task automatic t_prefix;
        up_round(5'b01_100, 0, 32'd1, 0, 32'd2, 0, 32'd4, 0, 0,
                 32'd7, 0, 0, "R9 prefix up");
        dn_round(32'd10, 32'd10, 32'd11, 32'd13, "R9 prefix down");
        up_round(5'b01_100, 0, 32'd1, 0, 32'd2, 1, 32'd4, 0, 1,
                 32'd5, 0, 0, "R9 prefix up local abstains");
        dn_round(32'd10, 32'd10, 32'd11, 32'd11, "R9 prefix down abstain");
    endtask

    task automatic t_suffix;
        up_round(5'b10_100, 0, 32'd1, 0, 32'd2, 0, 32'd4, 0, 0,
                 32'd7, 0, 0, "R10 suffix up");
        dn_round(32'd100, 32'd106, 32'd104, 32'd100, "R10 suffix down");
    endtask

    task automatic t_gor;
        up_round(5'b11_010, 0, 32'd2, 0, 32'd0, 0, 32'd5, 0, 0,
                 32'd1, 0, 0, "R11 global OR set");
        dn_round(32'hFFFF_FFFF, 32'd1, 32'd1, 32'd1, "R11 global OR down");
        up_round(5'b11_000, 0, 32'hFE, 0, 32'hFFFF_FFF0, 0, 32'h2, 0, 1,
                 32'd0, 0, 0, "R11 global OR clear");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_reduce_or();
        t_xor_max();
        t_sadd();
        t_uadd();
        t_all_abstain();
        t_prefix();
        t_suffix();
        t_gor();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule